// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port word memory for one clock domain. It takes one command per clock and moves that command's data a fixed two edges later. The command is an address, a read/write select and a load/advance control. Reads and writes line up in the same data slot. Because of that, a read may follow a write, or a write a read, on consecutive clocks with no idle bus cycle between them. The 36-bit word is split into four 9-bit lanes, and each lane has its own active-low write enable. A built-in four-beat burst generator supplies addresses after a load. It steps through them in a linear or an interleaved order.

The data bus is modelled as separate input, output and drive-enable signals. The block has no valid/ready flow control: the latency is fixed, and the only back-pressure is the active-low clock enable. That input freezes the whole pipeline, including writes to the array. A sleep input freezes the pipeline in the same way, and the stored contents are kept. An asynchronous output-enable input can turn the drivers off at any moment.

Timing convention: a command is captured at rising edge t. Its data slot is the clock period between edges t+1 and t+2. A read drives its word in that period. A write takes its word from the input bus at edge t+2.

Top module: `zts_sram`

## Requirements
- R1: A command captured at edge t with the select enables true (ce_a_n=0, ce_b=1, ce_c_n=0) and ld_n low moves its data in the period between edges t+1 and t+2. For a read (rd=1), dq_oe is high in that period and dq_out holds the stored word. For a write (rd=0), dq_in is written at edge t+2.
- R2: Read and write commands may be issued on consecutive clocks in any order with no idle cycle. A read issued on the clock right after a write to the same address returns the newly written lanes.
- R3: Lane i is bits 9i+8..9i and is written only when byte_we_n[i] is 0 in that write's command cycle. The other lanes keep their old contents. byte_we_n has no effect on reads.
- R4: A clock edge at which ck_en_n is 1 has no effect. No command is accepted, no write reaches the array, and dq_out and dq_oe hold their values.
- R5: A load cycle (ld_n=0) with any enable false starts no operation and ends any burst. dq_oe is low in its data slot. Commands already in the pipeline still complete.
- R6: dq_oe is low during the data slot of a write, so the host can drive dq_in there.
- R7: With ld_n high, an active burst issues the next beat at address {base[ADDR_W-1:2], ofs}. Beat k after the load (k=1,2,3,0,...) uses ofs = (base[1:0]+k) mod 4 when burst_lin=1 and ofs = base[1:0] XOR k when burst_lin=0, wrapping after four beats. The read/write type is the one latched at the load; rd is ignored on advance cycles. With no active burst, ld_n high issues nothing.
- R8: out_en_n high forces dq_oe low at once, without waiting for a clock edge.
- R9: After a rising edge sampled with rst_n=0, dq_oe is low and no burst is active.
- R10: While sleep is 1, clock edges have no effect, exactly as with ck_en_n=1, and the stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline and burst state |
| ck_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sleep | input | 1 | High gates the internal clock; contents kept |
| ce_a_n | input | 1 | Active-low chip enable |
| ce_b | input | 1 | Active-high chip enable |
| ce_c_n | input | 1 | Active-low chip enable |
| ld_n | input | 1 | Low loads a new command, high advances the burst |
| rd | input | 1 | 1 read, 0 write; used on load cycles only |
| addr | input | ADDR_W | Word address |
| byte_we_n | input | 4 | Active-low per-lane write enables |
| burst_lin | input | 1 | 1 linear burst order, 0 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
Assertions check four things on every cycle. After two active edges, a read load turns dq_oe on, while a write or a deselect turns it off. A stalled edge leaves the output and drive state unchanged. Reset clears the drive. A burst advance steps the beat counter by one and keeps the latched direction. Only the bench scenarios can show that the right data lands in the right place: lane masking, same-address forwarding between neighbouring commands, both burst orders with wrap-around, pending writes completing after a deselect, and the asynchronous action of out_en_n. The bench checks all of these against its own array model and its own burst arithmetic.

// File: rtl/zts_pkg.sv
package zts_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int OFS_W  = 2;

  typedef logic [LANES-1:0] lane_mask_t;

  typedef struct packed {
    logic       valid;
    logic       rd;
    lane_mask_t wmask;
  } slot_ctl_t;
endpackage

// File: rtl/zts_burst.sv
module zts_burst #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ld_n,
  input  logic              sel,
  input  logic              rd_in,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cmd_valid,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr
);
  import zts_pkg::*;

  logic              active_q;
  logic              rd_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  cnt_q;
  logic [OFS_W-1:0]  ofs;

  always_comb begin
    if (linear) ofs = base_q[OFS_W-1:0] + cnt_q;
    else        ofs = base_q[OFS_W-1:0] ^ cnt_q;
  end

  always_comb begin
    if (!ld_n) begin
      cmd_valid = sel;
      cmd_rd    = rd_in;
      cmd_addr  = addr_in;
    end else begin
      cmd_valid = active_q;
      cmd_rd    = rd_q;
      cmd_addr  = {base_q[ADDR_W-1:OFS_W], ofs};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (go) begin
      if (!ld_n) begin
        active_q <= sel;
        base_q   <= addr_in;
        rd_q     <= rd_in;
        cnt_q    <= OFS_W'(1);
      end else if (active_q) begin
        cnt_q <= cnt_q + OFS_W'(1);
      end
    end
  end

  // R7: an advance keeps the direction latched at load
  a_r7_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld_n) |=> $stable(rd_q));

  // R7: each advance of a live burst moves to the next beat
  a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld_n && active_q) |=> (cnt_q == $past(cnt_q) + OFS_W'(1)));

  // R5: a deselecting load leaves no live burst
  a_r5_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n && !sel) |=> !active_q);
endmodule

// File: rtl/zts_array.sv
module zts_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [LANES-1:0]         wmask,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LANE_W*LANES-1:0]  wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [LANE_W*LANES-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[l]) store[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/zts_pipe.sv
module zts_pipe #(
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic                        cmd_valid,
  input  logic                        cmd_rd,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [zts_pkg::LANES-1:0]   byte_we_n,
  input  logic [zts_pkg::WORD_W-1:0]  dq_in,
  input  logic [zts_pkg::WORD_W-1:0]  arr_rdata,
  output logic [ADDR_W-1:0]           arr_raddr,
  output logic                        arr_we,
  output logic [ADDR_W-1:0]           arr_waddr,
  output logic [zts_pkg::LANES-1:0]   arr_wmask,
  output logic [zts_pkg::WORD_W-1:0]  arr_wdata,
  output logic                        drive,
  output logic [zts_pkg::WORD_W-1:0]  dq_q
);
  import zts_pkg::*;

  slot_ctl_t         s1_q, s2_q, s1_d;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic [WORD_W-1:0] merged;
  logic              fwd_hit;

  always_comb begin
    s1_d.valid = cmd_valid;
    s1_d.rd    = cmd_rd;
    s1_d.wmask = cmd_rd ? '0 : ~byte_we_n;
  end

  assign arr_raddr = s1_addr_q;
  assign arr_we    = go && rst_n && s2_q.valid && !s2_q.rd;
  assign arr_waddr = s2_addr_q;
  assign arr_wmask = s2_q.wmask;
  assign arr_wdata = dq_in;

  // a write committing on this edge is bypassed into a read of the same word
  assign fwd_hit = s2_q.valid && !s2_q.rd && (s2_addr_q == s1_addr_q);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (fwd_hit && s2_q.wmask[l])
      ? dq_in[l*LANE_W +: LANE_W] : arr_rdata[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q      <= '0;
      s2_q      <= '0;
      s1_addr_q <= '0;
      s2_addr_q <= '0;
      drive     <= 1'b0;
      dq_q      <= '0;
    end else if (go) begin
      s1_q      <= s1_d;
      s1_addr_q <= cmd_addr;
      s2_q      <= s1_q;
      s2_addr_q <= s1_addr_q;
      drive     <= s1_q.valid && s1_q.rd;
      if (s1_q.valid && s1_q.rd) dq_q <= merged;
    end
  end

  // R4 / R10: a frozen edge changes neither data nor drive state
  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(dq_q) && $stable(drive)));

  // R1: a read issued two active edges ago drives the bus
  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_valid && cmd_rd) ##1 go |=> drive);

  // R6: the data slot of a write is not driven
  a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_valid && !cmd_rd) ##1 go |=> !drive);

  // R5: a deselect slot is not driven
  a_r5_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cmd_valid) ##1 go |=> !drive);

  // R9: reset turns the drivers off
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !drive);
endmodule

// File: rtl/zts_sram.sv
module zts_sram #(
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ck_en_n,
  input  logic                        sleep,
  input  logic                        ce_a_n,
  input  logic                        ce_b,
  input  logic                        ce_c_n,
  input  logic                        ld_n,
  input  logic                        rd,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [zts_pkg::LANES-1:0]   byte_we_n,
  input  logic                        burst_lin,
  input  logic                        out_en_n,
  input  logic [zts_pkg::WORD_W-1:0]  dq_in,
  output logic [zts_pkg::WORD_W-1:0]  dq_out,
  output logic                        dq_oe
);
  import zts_pkg::*;

  logic              go, sel;
  logic              cmd_valid, cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] arr_raddr, arr_waddr;
  logic              arr_we;
  logic [LANES-1:0]  arr_wmask;
  logic [WORD_W-1:0] arr_wdata, arr_rdata;
  logic              drive;

  assign go  = !ck_en_n && !sleep;
  assign sel = !ce_a_n && ce_b && !ce_c_n;

  zts_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .go(go), .ld_n(ld_n), .sel(sel),
    .rd_in(rd), .linear(burst_lin), .addr_in(addr),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr)
  );

  zts_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .byte_we_n(byte_we_n), .dq_in(dq_in), .arr_rdata(arr_rdata),
    .arr_raddr(arr_raddr), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wmask(arr_wmask), .arr_wdata(arr_wdata),
    .drive(drive), .dq_q(dq_out)
  );

  zts_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .we(arr_we), .wmask(arr_wmask), .waddr(arr_waddr),
    .wdata(arr_wdata), .raddr(arr_raddr), .rdata(arr_rdata)
  );

  assign dq_oe = drive && !out_en_n;
endmodule

// File: tb/zts_sram_tb.sv
module zts_sram_tb_top;
  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam logic [2:0] SEL  = 3'b010; // {ce_a_n, ce_b, ce_c_n}
  localparam logic [2:0] DSA  = 3'b110;
  localparam logic [2:0] DSB  = 3'b000;
  localparam logic [2:0] DSC  = 3'b011;

  logic clk = 1'b0;
  logic rst_n, ck_en_n, sleep, ce_a_n, ce_b, ce_c_n, ld_n, rd, burst_lin, out_en_n;
  logic [AW-1:0] addr;
  logic [3:0]  byte_we_n;
  logic [35:0] dq_in, dq_out;
  logic        dq_oe;

  always #10 clk = ~clk;

  zts_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ck_en_n(ck_en_n), .sleep(sleep),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .ld_n(ld_n), .rd(rd),
    .addr(addr), .byte_we_n(byte_we_n), .burst_lin(burst_lin),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [35:0]   refm [NW];
  logic          q1v, q1r, q2v, q2r;
  logic [AW-1:0] q1a, q2a;
  logic [3:0]    q1m, q2m;
  logic          bact, brd;
  logic [AW-1:0] bbase;
  logic [1:0]    bcnt;
  logic          exp_drv;
  logic [35:0]   exp_q;
  int            wseq = 0;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic ld_i, input logic rd_i, input logic [AW-1:0] a_i,
                      input logic [3:0] be_i, input logic [2:0] ce_i,
                      input logic cke_i, input logic slp_i, input string tag);
    logic ov, orr, go, sel;
    logic [AW-1:0] oa;
    logic [3:0] om;
    logic [1:0] ofs;
    ld_n = ld_i; rd = rd_i; addr = a_i; byte_we_n = be_i;
    {ce_a_n, ce_b, ce_c_n} = ce_i; ck_en_n = cke_i; sleep = slp_i; out_en_n = 1'b0;
    wseq++;
    dq_in = (q2v && !q2r) ? (36'(wseq) * 36'd2654435761) ^ 36'h5A5A5A5A5 : 36'hDEADBEEF0;
    go  = rst_n && !cke_i && !slp_i;
    sel = !ce_i[2] && ce_i[1] && !ce_i[0];
    ofs = burst_lin ? bbase[1:0] + bcnt : bbase[1:0] ^ bcnt;
    if (!ld_i) begin ov = sel; orr = rd_i; oa = a_i; end
    else begin ov = bact; orr = brd; oa = {bbase[AW-1:2], ofs}; end
    om = orr ? 4'h0 : ~be_i;
    @(posedge clk);
    if (!rst_n) begin
      q1v = 0; q2v = 0; bact = 0; exp_drv = 0;
    end else if (go) begin
      if (q2v && !q2r)
        for (int l = 0; l < 4; l++) if (q2m[l]) refm[q2a][l*9 +: 9] = dq_in[l*9 +: 9];
      if (!ld_i) begin bact = sel; bbase = a_i; brd = rd_i; bcnt = 2'd1; end
      else if (bact) bcnt = bcnt + 2'd1;
      q2v = q1v; q2r = q1r; q2a = q1a; q2m = q1m;
      q1v = ov;  q1r = orr; q1a = oa;  q1m = om;
      exp_drv = q2v && q2r;
      if (exp_drv) exp_q = refm[q2a];
    end
    @(negedge clk);
    chk(dq_oe === exp_drv, {tag, " dq_oe"}, 36'(dq_oe), 36'(exp_drv));
    if (exp_drv) chk(dq_out === exp_q, {tag, " dq_out"}, dq_out, exp_q);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input string tag);
    tick(1'b0, 1'b0, a, be, SEL, 1'b0, 1'b0, tag);
  endtask
  task automatic rdc(input logic [AW-1:0] a, input string tag);
    tick(1'b0, 1'b1, a, 4'(a), SEL, 1'b0, 1'b0, tag); // byte enables ignored on reads (R3)
  endtask
  task automatic idle(input string tag);
    tick(1'b0, 1'b0, '0, 4'h0, DSA, 1'b0, 1'b0, tag);
  endtask

  initial begin
    rst_n = 0; burst_lin = 1; out_en_n = 0; dq_in = '0;
    q1v = 0; q2v = 0; bact = 0; brd = 0; bbase = '0; bcnt = '0; exp_drv = 0; exp_q = '0;
    q1r = 0; q2r = 0; q1a = '0; q2a = '0; q1m = '0; q2m = '0;
    for (int i = 0; i < NW; i++) refm[i] = '0;
    @(negedge clk);
    // R9: reset state
    tick(1'b0, 1'b1, '0, 4'h0, SEL, 1'b0, 1'b0, "R9 reset");
    tick(1'b0, 1'b1, '0, 4'h0, SEL, 1'b0, 1'b0, "R9 reset");
    rst_n = 1;
    // R1: fill then read back every word
    for (int a = 0; a < NW; a++) wr(AW'(a), 4'h0, "R1 fill");
    for (int a = 0; a < NW; a++) rdc(AW'(a), "R1 readback");
    idle("R6 idle"); idle("R6 idle");
    // R2: back-to-back turnaround, read right after write of the same word
    for (int a = 0; a < NW; a += 3) begin
      wr(AW'(a), 4'h0, "R2 wr");
      rdc(AW'(a), "R2 rd same");
      rdc(AW'(a ^ 1), "R2 rd other");
      wr(AW'(a ^ 1), 4'h0, "R2 wr after rd");
    end
    idle("R2 idle"); idle("R2 idle");
    // R3: every lane mask, checked by immediate and later reads
    for (int m = 0; m < 16; m++) begin
      wr(AW'(m), 4'(m), "R3 masked");
      rdc(AW'(m), "R3 masked rd");
    end
    for (int m = 0; m < 16; m++) rdc(AW'(m), "R3 recheck");
    idle("R3 idle"); idle("R3 idle");
    // R4: stalls with garbage inputs between commands
    wr(6'd5, 4'h0, "R4 wr");
    tick(1'b0, 1'b0, 6'd9, 4'h0, SEL, 1'b1, 1'b0, "R4 stall");
    tick(1'b0, 1'b1, 6'd7, 4'h0, DSA, 1'b1, 1'b0, "R4 stall");
    rdc(6'd5, "R4 rd");
    tick(1'b0, 1'b0, 6'd5, 4'h0, SEL, 1'b1, 1'b0, "R4 stall");
    idle("R4 idle");
    tick(1'b1, 1'b0, 6'd5, 4'h0, SEL, 1'b1, 1'b0, "R4 stall out");
    idle("R4 idle");
    rdc(6'd9, "R4 untouched"); rdc(6'd5, "R4 rd"); idle("R4 idle"); idle("R4 idle");
    // R10: sleep behaves as a stall and keeps contents
    rdc(6'd12, "R10 rd");
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 6'd12, 4'h0, SEL, 1'b0, 1'b1, "R10 sleep");
    idle("R10 idle"); idle("R10 idle");
    for (int a = 8; a < 16; a++) rdc(AW'(a), "R10 kept");
    idle("R10 idle"); idle("R10 idle");
    // R7: bursts in both orders, all start offsets, with wrap
    for (int lin = 0; lin < 2; lin++) begin
      burst_lin = lin[0];
      for (int s = 0; s < 4; s++) begin
        wr(AW'(32 + s), 4'h0, "R7 burst wr load");
        for (int k = 0; k < 3; k++)
          tick(1'b1, k[0], '0, 4'(k * 5), SEL, 1'b0, 1'b0, "R7 burst wr adv");
        rdc(AW'(32 + s), "R7 burst rd load");
        for (int k = 0; k < 5; k++)
          tick(1'b1, k[0], 6'd63, 4'h0, SEL, 1'b0, 1'b0, "R7 burst rd adv");
        idle("R7 idle"); idle("R7 idle");
      end
    end
    // R5: deselect by each enable ends the burst, pending ops complete
    rdc(6'd40, "R5 rd");
    wr(6'd41, 4'h0, "R5 wr pending");
    tick(1'b0, 1'b1, 6'd3, 4'h0, DSA, 1'b0, 1'b0, "R5 desel a");
    tick(1'b1, 1'b1, 6'd3, 4'h0, SEL, 1'b0, 1'b0, "R5 no burst");
    tick(1'b1, 1'b0, 6'd3, 4'h0, SEL, 1'b0, 1'b0, "R5 no burst");
    rdc(6'd20, "R5 rd");
    tick(1'b0, 1'b1, 6'd3, 4'h0, DSB, 1'b0, 1'b0, "R5 desel b");
    tick(1'b1, 1'b1, 6'd3, 4'h0, SEL, 1'b0, 1'b0, "R5 no burst");
    wr(6'd22, 4'h0, "R5 wr");
    tick(1'b0, 1'b1, 6'd3, 4'h0, DSC, 1'b0, 1'b0, "R5 desel c");
    tick(1'b1, 1'b0, 6'd3, 4'h0, SEL, 1'b0, 1'b0, "R5 no burst");
    idle("R5 idle");
    rdc(6'd41, "R5 pending done"); rdc(6'd22, "R5 pending done");
    rdc(6'd3, "R5 untouched"); idle("R5 idle"); idle("R5 idle");
    // R8: asynchronous output enable
    rdc(6'd7, "R8 rd");
    idle("R8 slot");
    out_en_n = 1; #2;
    chk(dq_oe === 1'b0, "R8 oe off", 36'(dq_oe), 36'h0);
    out_en_n = 0; #2;
    chk(dq_oe === 1'b1, "R8 oe on", 36'(dq_oe), 36'h1);
    idle("R8 idle");
    // R9: reset mid-burst clears burst and drive
    rdc(6'd44, "R9 load");
    tick(1'b1, 1'b1, '0, 4'h0, SEL, 1'b0, 1'b0, "R9 adv");
    rst_n = 0;
    tick(1'b1, 1'b1, '0, 4'h0, SEL, 1'b0, 1'b0, "R9 in reset");
    rst_n = 1;
    for (int k = 0; k < 4; k++) tick(1'b1, 1'b1, '0, 4'h0, SEL, 1'b0, 1'b0, "R9 no burst");
    rdc(6'd44, "R9 rd"); idle("R9 idle"); idle("R9 idle");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule